// File: doc/BRIEF.md
# Bussed Nibble Register Memory

This block is a tiny memory array of four rows, each four bits wide, built from edge-triggered storage cells that share one bidirectional data bus. A two-bit row address chooses which row sees the write strobe or the output enable. Both controls are active low. Data on the bus is stored when the write strobe returns high. The addressed row is put onto the bus only while output enable is low. At all other times every bus driver is released to high impedance.

The controls are sampled on the block clock. A write commits to storage in the first cycle the strobe is sampled high after being low. It uses the address and bus value of the last cycle the strobe was sampled low. If the strobe and output enable are seen low together, the block flags a control error. It then keeps the bus released and drops the pending write. A board or testbench pull-up gives the bus a defined value when nothing drives it.

Top module: `nib_bus_mem`

## Requirements
- R1: After reset every row holds 4'h0, `ctl_err` is low and the bus is not driven while `oe_n` is high.
- R2: While `oe_n` is low and `wr_n` is high, `db` shows the content of the addressed row in the same cycle, with bit i of the row on `db[i]`.
- R3: A write takes the `addr` and `db` values from the last clock edge at which `wr_n` was sampled low. It stores them in the first clock edge at which `wr_n` is sampled high again. No row changes at any other edge.
- R4: A write changes only the addressed row. The other three rows keep their contents.
- R5: While `oe_n` is high the block never drives `db`, so newly written data stays hidden until `oe_n` goes low.
- R6: While `wr_n` and `oe_n` are both low the bus is not driven. `ctl_err` is high in the cycle after each clock edge that sampled both low, and low otherwise.
- R7: If `oe_n` is sampled low at any edge while `wr_n` is sampled low, the write of that strobe pulse stores nothing.
- R8: Address value k (0 to 3) selects row k for both reading and writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Row select |
| wr_n | input | 1 | Active-low write strobe, stores on its return high |
| oe_n | input | 1 | Active-low output enable |
| db | inout | 4 | Shared bidirectional data bus |
| ctl_err | output | 1 | High the cycle after write strobe and output enable were both low |

## Verification
On every cycle the assertions check four things. At most one row's driver is enabled. No driver is on while the strobe is low. A row changes only on a commit, and every commit follows a strobe sampled low. A conflict cycle blocks the next commit. Only the bench's scenarios can show the values that come back. These are the data read from each address, the neighbours left untouched by a write, the bus floating to the pull-up level while the enable is high, and the content kept after an aborted pulse. The bench checks them against its own model.

// File: rtl/nib_bus_pkg.sv
`timescale 1ns/1ps
package nib_bus_pkg;
  localparam int unsigned NROWS_DEF = 4;
  localparam int unsigned NBITS_DEF = 4;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_CLASH = 2'd3
  } bus_mode_e;

  function automatic bus_mode_e classify(input logic wr_n, input logic oe_n);
    if (!wr_n && !oe_n) return BUS_CLASH;
    else if (!wr_n)     return BUS_WRITE;
    else if (!oe_n)     return BUS_READ;
    else                return BUS_IDLE;
  endfunction
endpackage

// File: rtl/nib_rst_sync.sv
`timescale 1ns/1ps
module nib_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nib_strobe_ctl.sv
`timescale 1ns/1ps
module nib_strobe_ctl
  import nib_bus_pkg::*;
#(
  parameter int unsigned AW    = 2,
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] bus_in,
  output logic             commit,
  output logic             rd_ok,
  output logic [AW-1:0]    wr_addr,
  output logic [WIDTH-1:0] wr_data,
  output logic             err
);
  bus_mode_e        mode;
  logic             wr_q, wr_d;
  logic             abort_q, abort_d;
  logic             err_q, err_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic             lat_en;

  always_comb begin
    mode    = classify(wr_n, oe_n);
    lat_en  = !wr_n;
    wr_d    = wr_n;
    addr_d  = lat_en ? addr   : addr_q;
    data_d  = lat_en ? bus_in : data_q;
    err_d   = (mode == BUS_CLASH);
    if (wr_n) abort_d = 1'b0;
    else      abort_d = abort_q | (mode == BUS_CLASH);
    commit  = wr_n && !wr_q && !abort_q;
    rd_ok   = (mode == BUS_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b1;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      abort_q <= abort_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (lat_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign err     = err_q;

  AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(wr_n)); // R3
  AST_CLASH_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !oe_n) |=> !commit); // R7
endmodule

// File: rtl/nib_row_decode.sv
`timescale 1ns/1ps
module nib_row_decode #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   wr_addr,
  input  logic [AW-1:0]   rd_addr,
  input  logic            commit,
  input  logic            rd_ok,
  output logic [ROWS-1:0] row_we,
  output logic [ROWS-1:0] row_oe
);
  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign row_we[r] = commit && (wr_addr == AW'(r));
    assign row_oe[r] = rd_ok  && (rd_addr == AW'(r));
  end

  AST_ONE_ROW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_oe)); // R4
  AST_ONE_ROW_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we)); // R4
endmodule

// File: rtl/nib_store_row.sv
`timescale 1ns/1ps
module nib_store_row #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    logic cell_q, cell_d;
    always_comb cell_d = d[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q <= 1'b0;
      else if (we) cell_q <= cell_d;
    end
    assign q[b] = cell_q;
  end

  AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R3
endmodule

// File: rtl/nib_bus_mem.sv
`timescale 1ns/1ps
module nib_bus_mem
  import nib_bus_pkg::*;
#(
  parameter int unsigned ROWS  = NROWS_DEF,
  parameter int unsigned WIDTH = NBITS_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(ROWS)-1:0]  addr,
  input  logic                     wr_n,
  input  logic                     oe_n,
  inout  wire  [WIDTH-1:0]         db,
  output logic                     ctl_err
);
  localparam int unsigned AW = $clog2(ROWS);

  logic             rst_s;
  logic             commit, rd_ok;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_data;
  logic [ROWS-1:0]  row_we, row_oe;
  logic [WIDTH-1:0] row_q [ROWS];
  logic [WIDTH-1:0] rd_bus;
  logic             drv_en;
  logic [WIDTH-1:0] bus_in;

  assign bus_in = db;

  nib_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  nib_strobe_ctl #(.AW(AW), .WIDTH(WIDTH)) u_ctl (
    .clk(clk), .rst_n(rst_s), .wr_n(wr_n), .oe_n(oe_n), .addr(addr),
    .bus_in(bus_in), .commit(commit), .rd_ok(rd_ok),
    .wr_addr(wr_addr), .wr_data(wr_data), .err(ctl_err));

  nib_row_decode #(.ROWS(ROWS), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_s), .wr_addr(wr_addr), .rd_addr(addr),
    .commit(commit), .rd_ok(rd_ok), .row_we(row_we), .row_oe(row_oe));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    nib_store_row #(.WIDTH(WIDTH)) u_row (
      .clk(clk), .rst_n(rst_s), .we(row_we[r]), .d(wr_data), .q(row_q[r]));
  end

  always_comb begin
    rd_bus = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_oe[r]) rd_bus = rd_bus | row_q[r];
    end
    drv_en = |row_oe;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_drv
    assign db[b] = drv_en ? rd_bus[b] : 1'bz;
  end

  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_n |-> !drv_en); // R6
  AST_NO_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    oe_n |-> !drv_en); // R5
endmodule

// File: tb/sim_nib_bus_mem.sv
`timescale 1ns/1ps
module sim_nib_bus_mem;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_n, oe_n;
  logic       tb_drv;
  logic [3:0] tb_val;
  logic       ctl_err;
  wire  [3:0] db;
  logic [3:0] mdl [4];
  int unsigned total = 0, bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  assign db = tb_drv ? tb_val : 4'bzzzz;
  pullup (db[0]);
  pullup (db[1]);
  pullup (db[2]);
  pullup (db[3]);

  nib_bus_mem u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n),
                  .oe_n(oe_n), .db(db), .ctl_err(ctl_err));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] v);
    tick(); addr = a; tb_val = v; tb_drv = 1'b1; wr_n = 1'b0; oe_n = 1'b1;
    tick(); wr_n = 1'b1;
    tick(); tb_drv = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [3:0] v);
    tick(); addr = a; tb_drv = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
    #1 v = db;
    tick(); oe_n = 1'b1;
  endtask

  function automatic logic [3:0] expect_row(input logic [1:0] a);
    return mdl[a];
  endfunction

  initial begin
    logic [3:0] got;
    int unsigned seed;
    rst_n = 1'b0; addr = '0; wr_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0; tb_val = '0;
    for (int i = 0; i < 4; i++) mdl[i] = 4'h0;
    seed = $urandom(32'd2024);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    #1;
    check("R1 err after reset", {3'b0, ctl_err}, 4'h0);
    check("R1 bus released", db, 4'hF);
    for (int r = 0; r < 4; r++) begin
      do_read(r[1:0], got);
      check("R1 row zero", got, 4'h0);
    end
    // R8 / R4: distinct value in each row, read back by address
    for (int r = 0; r < 4; r++) begin
      do_write(r[1:0], 4'(r * 3 + 1));
      mdl[r] = 4'(r * 3 + 1);
    end
    for (int r = 0; r < 4; r++) begin
      do_read(r[1:0], got);
      check("R8 R2 row select", got, expect_row(r[1:0]));
    end
    // R5: written data hidden while oe_n high
    tick(); addr = 2'd2; tb_val = 4'h6; tb_drv = 1'b1; wr_n = 1'b0;
    tick(); wr_n = 1'b1;
    tick(); tb_drv = 1'b0; #1;
    mdl[2] = 4'h6;
    check("R5 hidden while oe high", db, 4'hF);
    do_read(2'd2, got);
    check("R5 visible after oe low", got, 4'h6);
    // R4: neighbours unchanged
    do_read(2'd1, got); check("R4 neighbour kept", got, mdl[1]);
    do_read(2'd3, got); check("R4 neighbour kept", got, mdl[3]);
    // R3: write takes last-low data, commits on first high sample
    tick(); addr = 2'd0; tb_val = 4'h9; tb_drv = 1'b1; wr_n = 1'b0;
    tick(); tb_val = 4'hA;
    tick(); wr_n = 1'b1;
    tick(); tb_drv = 1'b0;
    mdl[0] = 4'hA;
    do_read(2'd0, got); check("R3 last low value", got, 4'hA);
    // R6/R7: clash for whole pulse
    tick(); addr = 2'd1; tb_drv = 1'b0; wr_n = 1'b0; oe_n = 1'b0;
    #1 check("R6 bus released on clash", db, 4'hF);
    tick(); #1;
    check("R6 err raised", {3'b0, ctl_err}, 4'h1);
    wr_n = 1'b1; oe_n = 1'b1;
    tick(); #1;
    check("R6 err cleared", {3'b0, ctl_err}, 4'h0);
    do_read(2'd1, got); check("R7 no store on clash", got, mdl[1]);
    // R7: brief oe_n low inside a strobe pulse
    tick(); addr = 2'd3; tb_val = 4'h0; tb_drv = 1'b1; wr_n = 1'b0;
    tick(); oe_n = 1'b0;
    tick(); oe_n = 1'b1;
    tick(); wr_n = 1'b1;
    tick(); tb_drv = 1'b0;
    do_read(2'd3, got); check("R7 aborted pulse", got, mdl[3]);
    // random traffic
    for (int n = 0; n < 200; n++) begin
      logic [1:0] a;
      logic [3:0] v;
      a = 2'($urandom);
      v = 4'($urandom);
      if ($urandom % 2) begin
        do_write(a, v); mdl[a] = v;
      end else begin
        do_read(a, got); check("R2 random read", got, expect_row(a));
      end
    end
    for (int r = 0; r < 4; r++) begin
      do_read(r[1:0], got); check("R3 final contents", got, expect_row(r[1:0]));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule